// File: doc/BRIEF.md
# Crossbar Nibble/Byte Permutation Unit

This execution unit does table-lookup permutations for a RISC-V style integer pipeline. The second source operand is read as a row of small index fields. Each field picks one element out of the first source operand, and that element is placed in the same field position of the result. The element size is either 4 bits or 8 bits, and the `funct3` field of the instruction selects which. Both sizes share one decode path and one output register.

The datapath width `XLEN` is a parameter and may be 32 or 64. An instruction is presented with `in_valid` together with both source values and an extension-enable input. Exactly one cycle later the unit returns a registered result, an output strobe, and an illegal flag. The illegal flag is raised for any word the unit does not accept. The register file, writeback and hazard logic sit outside the block.

Top module: `xbar_perm_unit`

## Requirements
- R1: With opcode bits [6:0] = 0110011, bits [31:25] = 0010100, funct3 bits [14:12] = 010 and `ext_en` high, each 4-bit field i of `op_b` gives an index k. Result nibble i is then nibble k of `op_a`.
- R2: With the same opcode and bits [31:25], funct3 = 100 and `ext_en` high, each byte i of `op_b` gives an index k. Result byte i is then byte k of `op_a`.
- R3: When index × element width is at or beyond XLEN, the result element is zero. For XLEN = 32 this means nibble indices 8–15 and byte indices 4–255. For XLEN = 64 it means byte indices 8–255.
- R4: Any instruction word that does not match either encoding is illegal. This covers a wrong opcode, a wrong bits [31:25], and any funct3 other than 010 or 100. An illegal word gives `out_illegal` = 1 with `out_valid` = 1 and `out_result` = 0.
- R5: When `ext_en` is low, both encodings are illegal. They give `out_illegal` = 1 and a zero result.
- R6: `out_valid` rises exactly one cycle after `in_valid`, and the result and flag are registered.
- R7: A cycle with `in_valid` low produces `out_valid` = 0, `out_illegal` = 0 and `out_result` = 0 on the next cycle.
- R8: The operands take part without any sign or zero extension, and all XLEN result bits are written. In a 64-bit build the upper half of the result carries permuted data.
- R9: While `rst` is high, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present |
| ext_en | input | 1 | Permutation instructions are enabled |
| instr | input | 32 | Instruction word |
| op_a | input | XLEN | Source table (elements to pick from) |
| op_b | input | XLEN | Index fields |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_illegal | output | 1 | The word was not accepted |
| out_result | output | XLEN | Permuted result |

## Verification
On every cycle the assertions check the timing relation: valid in leads to valid out one cycle later, and an idle input gives an all-zero output. They also check that a disabled or badly encoded word is flagged with a zero result, and that a legal word is never flagged. The values inside each element can only be shown by the bench's scenarios. These compare against a loop model for both widths, using identity tables, all-ones indices, out-of-range bytes and random operands. The bench runs a 64-bit and a 32-bit instance side by side.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam logic [6:0] OPC_REG_OP  = 7'b0110011;
    localparam logic [6:0] F7_XBAR     = 7'b0010100;
    localparam logic [2:0] F3_NIBBLE   = 3'b010;
    localparam logic [2:0] F3_BYTE     = 3'b100;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_NIBBLE = 2'd1,
        SEL_BYTE   = 2'd2
    } elem_sel_e;

    typedef struct packed {
        elem_sel_e sel;
        logic      illegal;
    } xbar_dec_t;

    function automatic xbar_dec_t decode_word(input logic [31:0] word, input logic enable);
        xbar_dec_t d;
        logic      shape_ok;
        d.sel     = SEL_NONE;
        d.illegal = 1'b1;
        shape_ok  = enable && (word[6:0] == OPC_REG_OP) && (word[31:25] == F7_XBAR);
        if (shape_ok) begin
            if (word[14:12] == F3_NIBBLE) begin
                d.sel     = SEL_NIBBLE;
                d.illegal = 1'b0;
            end else if (word[14:12] == F3_BYTE) begin
                d.sel     = SEL_BYTE;
                d.illegal = 1'b0;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/xbar_decode.sv
module xbar_decode
    import xbar_pkg::*;
(
    input  logic [31:0] instr,
    input  logic        ext_en,
    output xbar_dec_t   dec
);

    always_comb begin
        dec = decode_word(instr, ext_en);
    end

endmodule

// File: rtl/xbar_lane_sel.sv
module xbar_lane_sel #(
    parameter int XLEN = 64,
    parameter int EW   = 4
) (
    input  logic [XLEN-1:0] table_in,
    input  logic [XLEN-1:0] index_in,
    output logic [XLEN-1:0] perm_out
);

    localparam int NEL = XLEN / EW;

    for (genvar g = 0; g < NEL; g++) begin : g_lane
        logic [EW-1:0] idx;
        logic [EW-1:0] elem;

        assign idx = index_in[g*EW +: EW];

        always_comb begin
            elem = '0;
            for (int k = 0; k < NEL; k++) begin
                if (32'(idx) == k) begin
                    elem = table_in[k*EW +: EW];
                end
            end
        end

        assign perm_out[g*EW +: EW] = elem;
    end

endmodule

// File: rtl/xbar_perm_unit.sv
module xbar_perm_unit
    import xbar_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            ext_en,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic            out_valid,
    output logic            out_illegal,
    output logic [XLEN-1:0] out_result
);

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;

    xbar_dec_t       dec;
    logic [XLEN-1:0] nib_perm;
    logic [XLEN-1:0] byte_perm;
    logic [XLEN-1:0] sel_perm;

    xbar_decode u_dec (
        .instr  (instr),
        .ext_en (ext_en),
        .dec    (dec)
    );

    xbar_lane_sel #(.XLEN(XLEN), .EW(NIB_W)) u_nib (
        .table_in (op_a),
        .index_in (op_b),
        .perm_out (nib_perm)
    );

    xbar_lane_sel #(.XLEN(XLEN), .EW(BYTE_W)) u_byte (
        .table_in (op_a),
        .index_in (op_b),
        .perm_out (byte_perm)
    );

    always_comb begin
        unique case (dec.sel)
            SEL_NIBBLE: sel_perm = nib_perm;
            SEL_BYTE:   sel_perm = byte_perm;
            default:    sel_perm = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_result  <= '0;
        end else begin
            out_valid   <= in_valid;
            out_illegal <= in_valid && dec.illegal;
            out_result  <= in_valid ? sel_perm : '0;
        end
    end

endmodule

// File: rtl/xbar_perm_chk.sv
module xbar_perm_chk
    import xbar_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            ext_en,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] op_a,
    input logic [XLEN-1:0] op_b,
    input logic            out_valid,
    input logic            out_illegal,
    input logic [XLEN-1:0] out_result
);

    logic word_shape;
    logic f3_known;
    assign word_shape = (instr[6:0] == OPC_REG_OP) && (instr[31:25] == F7_XBAR);
    assign f3_known   = (instr[14:12] == F3_NIBBLE) || (instr[14:12] == F3_BYTE);

    assert_valid_latency_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal && out_result == '0));

    assert_disabled_illegal_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ext_en) |=> (out_illegal && out_result == '0));

    assert_bad_word_illegal_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !(word_shape && f3_known)) |=> (out_valid && out_illegal && out_result == '0));

    assert_legal_accepted_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ext_en && word_shape && f3_known) |=> (out_valid && !out_illegal));

    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !out_illegal && out_result == '0));

endmodule

bind xbar_perm_unit xbar_perm_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .ext_en      (ext_en),
    .instr       (instr),
    .op_a        (op_a),
    .op_b        (op_b),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_result  (out_result)
);

// File: tb/tb_xbar_perm_unit.sv
module tb_xbar_perm_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        ext_en = 1'b1;
    logic [31:0] instr = '0;
    logic [63:0] a64 = '0;
    logic [63:0] b64 = '0;

    logic        v64, ill64, v32, ill32;
    logic [63:0] r64;
    logic [31:0] r32;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    xbar_perm_unit #(.XLEN(64)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ext_en(ext_en), .instr(instr),
        .op_a(a64), .op_b(b64),
        .out_valid(v64), .out_illegal(ill64), .out_result(r64)
    );

    xbar_perm_unit #(.XLEN(32)) dut32 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ext_en(ext_en), .instr(instr),
        .op_a(a64[31:0]), .op_b(b64[31:0]),
        .out_valid(v32), .out_illegal(ill32), .out_result(r32)
    );

    typedef struct {
        logic        v;
        logic        ill;
        logic [63:0] r64;
        logic [31:0] r32;
        string       tag;
    } exp_t;

    exp_t sb[$];

    function automatic logic [63:0] perm_model(logic [63:0] a, logic [63:0] b, int xlen, int ew);
        logic [63:0] r;
        logic [63:0] mask;
        r    = '0;
        mask = (64'd1 << ew) - 64'd1;
        for (int i = 0; i < xlen; i += ew) begin
            logic [63:0] idx;
            idx = (b >> i) & mask;
            if (idx * ew < xlen) r |= ((a >> (idx * ew)) & mask) << i;
        end
        return r;
    endfunction

    function automatic logic [31:0] mk_word(logic [6:0] f7, logic [2:0] f3, logic [6:0] opc);
        return {f7, 5'd3, 5'd2, f3, 5'd1, opc};
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic send(logic [31:0] w, logic [63:0] a, logic [63:0] b, logic en, logic v, string tag);
        exp_t e;
        logic legal;
        int   ew;
        @(negedge clk);
        instr = w; a64 = a; b64 = b; ext_en = en; in_valid = v;
        legal = en && w[6:0] == 7'b0110011 && w[31:25] == 7'b0010100 &&
                (w[14:12] == 3'b010 || w[14:12] == 3'b100);
        ew    = (w[14:12] == 3'b010) ? 4 : 8;
        e.v   = v;
        e.ill = v && !legal;
        e.r64 = (v && legal) ? perm_model(a, b, 64, ew) : 64'd0;
        e.r32 = (v && legal) ? perm_model({32'd0, a[31:0]}, {32'd0, b[31:0]}, 32, ew)
                             : 64'd0;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: samples a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "valid64",   {63'd0, v64},   {63'd0, e.v});
                check(e.tag, "illegal64", {63'd0, ill64}, {63'd0, e.ill});
                check(e.tag, "result64",  r64,            e.r64);
                check(e.tag, "valid32",   {63'd0, v32},   {63'd0, e.v});
                check(e.tag, "illegal32", {63'd0, ill32}, {63'd0, e.ill});
                check(e.tag, "result32",  {32'd0, r32},   {32'd0, e.r32});
            end
        end
    end

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog R6 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] w_nib, w_byte;
        w_nib  = mk_word(7'b0010100, 3'b010, 7'b0110011);
        w_byte = mk_word(7'b0010100, 3'b100, 7'b0110011);

        // R9: reset state, with stimulus present during reset
        @(negedge clk);
        in_valid = 1'b1; instr = w_nib; a64 = '1; b64 = '0;
        repeat (3) @(negedge clk);
        check("R9", "valid64",  {63'd0, v64}, 64'd0);
        check("R9", "result64", r64, 64'd0);
        check("R9", "result32", {32'd0, r32}, 64'd0);
        rst = 1'b0; in_valid = 1'b0;

        // R1: identity nibble table and a reversed one
        send(w_nib, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1, 1, "R1_identity");
        send(w_nib, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 1, 1, "R1_reverse");
        send(w_nib, 64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0000_0000, 1, 1, "R1_zero_idx");
        // R3: all-ones nibble indices (out of range only for 32-bit)
        send(w_nib, 64'hA5A5_5A5A_1234_8765, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, "R3_nib_ones");
        send(w_nib, 64'h1111_2222_3333_4444, 64'h0000_0000_8888_9999, 1, 1, "R3_nib_8plus");
        // R2: identity byte table and a rotation
        send(w_byte, 64'h8877_6655_4433_2211, 64'h0706_0504_0302_0100, 1, 1, "R2_identity");
        send(w_byte, 64'h8877_6655_4433_2211, 64'h0605_0403_0201_0007, 1, 1, "R2_rotate");
        // R3: out-of-range byte indices
        send(w_byte, 64'h8877_6655_4433_2211, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, "R3_byte_ones");
        send(w_byte, 64'h8877_6655_4433_2211, 64'h0809_0405_0304_0800, 1, 1, "R3_byte_edge");
        // R8: upper half carries data, no extension of operands
        send(w_byte, 64'hFF00_0000_0000_0080, 64'h0000_0000_0707_0707, 1, 1, "R8_upper_src");
        send(w_nib,  64'h8000_0000_0000_000F, 64'hF0F0_F0F0_0F0F_0F0F, 1, 1, "R8_upper_dst");
        // R4: bad encodings
        send(mk_word(7'b0010100, 3'b001, 7'b0110011), 64'h1234, 64'h0, 1, 1, "R4_funct3");
        send(mk_word(7'b0010100, 3'b110, 7'b0110011), 64'h1234, 64'h0, 1, 1, "R4_funct3b");
        send(mk_word(7'b0000100, 3'b010, 7'b0110011), 64'h1234, 64'h0, 1, 1, "R4_funct7");
        send(mk_word(7'b0010100, 3'b100, 7'b0010011), 64'h1234, 64'h0, 1, 1, "R4_opcode");
        // R5: extension disabled
        send(w_nib,  64'hFFFF, 64'h0, 0, 1, "R5_nib_off");
        send(w_byte, 64'hFFFF, 64'h0, 0, 1, "R5_byte_off");
        // R7: idle cycles between valid ones (R6 back-to-back)
        send(w_nib, 64'hFFFF, 64'h0, 1, 0, "R7_idle");
        send(w_byte, 64'h1, 64'h0, 1, 1, "R6_single");
        send(w_byte, 64'h1, 64'h0, 1, 0, "R7_idle2");
        // random operands, both element sizes
        for (int n = 0; n < 60; n++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (n % 3 == 0) rb = rb & 64'h0F0F_0F0F_0F0F_0F0F;
            send((n % 2 == 0) ? w_nib : w_byte, ra, rb, 1, 1, (n % 2 == 0) ? "R1_rand" : "R2_rand");
        end
        send(w_nib, 64'h0, 64'h0, 1, 0, "R7_tail");
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule